// File: doc/BRIEF.md
# Timer and Watchdog with Shared Prescaler

This block holds an 8-bit timer and a watchdog counter that share a single programmable prescaler. A 6-bit mode register sets four things:

- which counter the prescaler divides for;
- the division ratio;
- whether the timer counts instruction cycles or transitions on an external pin;
- which pin transition counts.

The counter that does not own the prescaler counts its own events undivided. The same 3-bit select code gives a ratio that is twice as large when the timer owns the prescaler as when the watchdog owns it.

Software loads the mode register with a single write strobe. It can load the timer value at any time. It clears the watchdog with a clear strobe. The watchdog oscillator is modelled as a one-cycle tick input. When the watchdog counter overflows, the block emits a one-cycle time-out pulse. The external pin level arrives already synchronized, and the block detects edges on it with one register.

Top module: `tps_timer_wdt`

## Requirements
- R1: After reset the timer reads 00h and the time-out output is low. The mode register resets to 3Fh, which selects pin transitions, the falling edge, the prescaler on the watchdog and select code 111.
- R2: A mode write loads mode_wdata_i in one cycle. Bits [2:0] are the ratio select, bit 3 the owner (0 timer, 1 watchdog), bit 4 the edge (0 rising, 1 falling) and bit 5 the source (0 cycle enable, 1 pin).
- R3: With source 0 the timer event is a cycle with cyc_en_i high. With source 1 the event is a pin transition, and cyc_en_i has no effect.
- R4: With source 1, edge 0 counts only low-to-high transitions of pin_i, and edge 1 counts only high-to-low transitions.
- R5: When the prescaler serves the timer, the timer advances once per 2^(s+1) events, where s is the select code.
- R6: When the prescaler serves the watchdog, the timer advances on every event. It never changes without an event or a write.
- R7: When the prescaler serves the watchdog, the watchdog advances once per 2^s ticks. When the prescaler serves the timer, the watchdog advances on every tick. The time-out pulse appears in the cycle after the tick that takes the 8-bit watchdog counter past FFh.
- R8: A timer write loads tmr_wdata_i and takes priority over a same-cycle increment. When the prescaler serves the timer, the write also clears it. When the prescaler serves the watchdog, its count is untouched.
- R9: wdt_clr_i clears the watchdog counter and suppresses a time-out in the next cycle. It clears the prescaler only while the prescaler serves the watchdog.
- R10: The timer wraps from FFh to 00h.
- R11: The time-out output is high for exactly one cycle per overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cyc_en_i | input | 1 | Instruction-cycle enable |
| pin_i | input | 1 | Synchronized external count pin |
| mode_we_i | input | 1 | Mode register write strobe |
| mode_wdata_i | input | 6 | Mode register write data |
| tmr_we_i | input | 1 | Timer write strobe |
| tmr_wdata_i | input | 8 | Timer write data |
| wdt_clr_i | input | 1 | Watchdog clear strobe |
| wdt_tick_i | input | 1 | Watchdog oscillator tick |
| tmr_value_o | output | 8 | Timer value |
| wdt_timeout_o | output | 1 | Watchdog time-out pulse |

## Verification
The assertions assume three things about the inputs. The pin input is already synchronous to clk_i. The strobes are single-cycle qualifiers sampled only at rising edges. pin_i is low while reset is asserted, so that no edge is seen on release.

The stimulus keeps within these assumptions. It drives every input on the falling clock edge and holds pin_i low through reset. It switches ownership of the prescaler only with a clear (the timer write or the watchdog clear) right behind it, so that every expected count starts from an empty prescaler.

// File: rtl/tps_pkg.sv
package tps_pkg;
  localparam int SEL_W  = 3;
  localparam int MODE_W = SEL_W + 3;

  typedef struct packed {
    logic             src_pin;
    logic             fall;
    logic             to_wdt;
    logic [SEL_W-1:0] sel;
  } mode_t;

  localparam mode_t MODE_RST = '{src_pin: 1'b1, fall: 1'b1, to_wdt: 1'b1, sel: '1};
endpackage

// File: rtl/tps_evt_src.sv
module tps_evt_src (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cyc_en_i,
  input  logic pin_i,
  input  logic src_pin_i,
  input  logic fall_i,
  output logic evt_o
);
  logic pin_q;
  logic rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= 1'b0;
    else         pin_q <= pin_i;
  end

  assign rise  = pin_i & ~pin_q;
  assign fall  = ~pin_i & pin_q;
  assign evt_o = src_pin_i ? (fall_i ? fall : rise) : cyc_en_i;

  AST_PIN_EVT_ON_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_pin_i && evt_o) |-> (pin_i != pin_q)) else $error("pin event without change"); // R4
endmodule

// File: rtl/tps_presc.sv
module tps_presc #(
  parameter int PS_W  = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_i,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             shift_i,
  output logic             tick_o
);
  localparam int EXP_W = SEL_W + 1;

  logic [PS_W-1:0]  cnt_q;
  logic [PS_W-1:0]  mask;
  logic [EXP_W-1:0] expo;
  logic             match;

  always_comb begin
    expo = {1'b0, sel_i} + EXP_W'(shift_i);
    for (int i = 0; i < PS_W; i++) mask[i] = (i < int'(expo));
  end

  assign match  = ((cnt_q & mask) == mask);
  assign tick_o = evt_i & ~clr_i & match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (evt_i)  cnt_q <= match ? '0 : cnt_q + 1'b1;
  end

  AST_TICK_NEEDS_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> evt_i) else $error("prescaler tick without event"); // R5
  AST_CLR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0)) else $error("prescaler not cleared"); // R9
endmodule

// File: rtl/tps_wdt.sv
module tps_wdt #(
  parameter int WDT_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clr_i,
  output logic timeout_o
);
  logic [WDT_W-1:0] cnt_q;
  logic             to_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      to_q  <= 1'b0;
    end else begin
      to_q <= tick_i & ~clr_i & (&cnt_q);
      if (clr_i)       cnt_q <= '0;
      else if (tick_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign timeout_o = to_q;

  AST_TO_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o) else $error("timeout longer than one cycle"); // R11
  AST_CLR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !timeout_o) else $error("timeout after clear"); // R9
  AST_TO_AFTER_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> (cnt_q == '0)) else $error("timeout without wrap"); // R7
endmodule

// File: rtl/tps_timer_wdt.sv
module tps_timer_wdt
  import tps_pkg::*;
#(
  parameter int TMR_W = 8,
  parameter int PS_W  = 8,
  parameter int WDT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cyc_en_i,
  input  logic              pin_i,
  input  logic              mode_we_i,
  input  logic [MODE_W-1:0] mode_wdata_i,
  input  logic              tmr_we_i,
  input  logic [TMR_W-1:0]  tmr_wdata_i,
  input  logic              wdt_clr_i,
  input  logic              wdt_tick_i,
  output logic [TMR_W-1:0]  tmr_value_o,
  output logic              wdt_timeout_o
);
  mode_t            mode_q;
  logic [TMR_W-1:0] tmr_q;
  logic             src_evt, ps_evt, ps_clr, ps_tick, tmr_inc, wdt_evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= MODE_RST;
    else if (mode_we_i) mode_q <= mode_t'(mode_wdata_i);
  end

  tps_evt_src u_evt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cyc_en_i  (cyc_en_i),
    .pin_i     (pin_i),
    .src_pin_i (mode_q.src_pin),
    .fall_i    (mode_q.fall),
    .evt_o     (src_evt)
  );

  // Prescaler steering: owner feeds it and may clear it
  assign ps_evt  = mode_q.to_wdt ? wdt_tick_i : src_evt;
  assign ps_clr  = mode_q.to_wdt ? wdt_clr_i  : tmr_we_i;
  assign tmr_inc = mode_q.to_wdt ? src_evt    : ps_tick;
  assign wdt_evt = mode_q.to_wdt ? ps_tick    : wdt_tick_i;

  tps_presc #(.PS_W(PS_W), .SEL_W(SEL_W)) u_presc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (ps_evt),
    .clr_i   (ps_clr),
    .sel_i   (mode_q.sel),
    .shift_i (~mode_q.to_wdt),
    .tick_o  (ps_tick)
  );

  tps_wdt #(.WDT_W(WDT_W)) u_wdt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (wdt_evt),
    .clr_i     (wdt_clr_i),
    .timeout_o (wdt_timeout_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       tmr_q <= '0;
    else if (tmr_we_i) tmr_q <= tmr_wdata_i;
    else if (tmr_inc)  tmr_q <= tmr_q + 1'b1;
  end

  assign tmr_value_o = tmr_q;

  AST_MODE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_we_i |=> (mode_q == $past(mode_wdata_i))) else $error("mode not loaded"); // R2
  AST_TMR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_we_i |=> (tmr_value_o == $past(tmr_wdata_i))) else $error("timer not loaded"); // R8
  AST_TMR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tmr_we_i && !tmr_inc) |=> $stable(tmr_value_o)) else $error("timer moved idle"); // R6
  AST_TMR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tmr_we_i && tmr_inc && (&tmr_q)) |=> (tmr_value_o == '0)) else $error("no wrap"); // R10
  AST_CYC_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q.src_pin && mode_q.to_wdt && $stable(pin_i) && !tmr_we_i) |=> $stable(tmr_value_o))
    else $error("cycle enable counted in pin mode"); // R3
endmodule

// File: tb/tps_timer_wdt_tb.sv
`timescale 1ns/1ps
module tps_timer_wdt_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cyc_en_i = 1'b0, pin_i = 1'b0, mode_we_i = 1'b0, tmr_we_i = 1'b0;
  logic       wdt_clr_i = 1'b0, wdt_tick_i = 1'b0;
  logic [5:0] mode_wdata_i = '0;
  logic [7:0] tmr_wdata_i = '0;
  logic [7:0] tmr_value_o;
  logic       wdt_timeout_o;
  int         n_chk = 0, n_err = 0;
  bit         done = 0;

  always #2.5 clk_i = ~clk_i;

  tps_timer_wdt u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cyc_en_i(cyc_en_i), .pin_i(pin_i),
    .mode_we_i(mode_we_i), .mode_wdata_i(mode_wdata_i), .tmr_we_i(tmr_we_i),
    .tmr_wdata_i(tmr_wdata_i), .wdt_clr_i(wdt_clr_i), .wdt_tick_i(wdt_tick_i),
    .tmr_value_o(tmr_value_o), .wdt_timeout_o(wdt_timeout_o)
  );

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk_i); endtask

  task automatic wr_mode(input logic [5:0] m);
    mode_we_i = 1'b1; mode_wdata_i = m; cyc(); mode_we_i = 1'b0;
  endtask

  task automatic wr_tmr(input logic [7:0] v);
    tmr_we_i = 1'b1; tmr_wdata_i = v; cyc(); tmr_we_i = 1'b0;
  endtask

  task automatic ev(); cyc_en_i = 1'b1; cyc(); cyc_en_i = 1'b0; endtask
  task automatic clr_wdt(); wdt_clr_i = 1'b1; cyc(); wdt_clr_i = 1'b0; endtask

  task automatic run_wdt(output int n);
    n = 0;
    wdt_tick_i = 1'b1;
    for (int k = 0; k < 40000; k++) begin
      cyc(); n++;
      if (wdt_timeout_o) break;
    end
    wdt_tick_i = 1'b0;
    cyc();
    chk("R11 pulse width", int'(wdt_timeout_o), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) cyc();
    rst_ni = 1'b1;
    cyc();
    chk("R1 timer reset", int'(tmr_value_o), 0);
    chk("R1 timeout reset", int'(wdt_timeout_o), 0);
    // Reset mode: pin source, falling edge, timer undivided; cycle enable ignored
    cyc_en_i = 1'b1;
    pin_i = 1'b1; cyc(); chk("R1 R3 rise ignored", int'(tmr_value_o), 0);
    pin_i = 1'b0; cyc(); chk("R1 R4 fall counted", int'(tmr_value_o), 1);
    cyc(); chk("R3 cyc_en ignored", int'(tmr_value_o), 1);
    cyc_en_i = 1'b0;

    // Timer ratio sweep, internal source, prescaler on timer
    for (int s = 0; s < 8; s++) begin
      int r;
      r = 2 << s;
      wr_mode(6'(s));
      wr_tmr(8'h00);
      for (int e = 1; e <= 3 * r; e++) begin
        ev();
        chk($sformatf("R5 ratio s=%0d e=%0d", s, e), int'(tmr_value_o), e / r);
        if (e % 3 == 0) begin
          cyc();
          chk("R3 idle hold", int'(tmr_value_o), e / r);
        end
      end
    end

    // Prescaler on watchdog: timer undivided
    wr_mode(6'h0F);
    wr_tmr(8'h00);
    for (int e = 1; e <= 5; e++) begin
      ev(); chk("R6 undivided timer", int'(tmr_value_o), e);
    end

    // Wrap
    wr_tmr(8'hFE);
    ev(); chk("R10 to FF", int'(tmr_value_o), 255);
    ev(); chk("R10 wrap", int'(tmr_value_o), 0);

    // Write priority over increment
    cyc_en_i = 1'b1; wr_tmr(8'h40); cyc_en_i = 1'b0;
    chk("R8 write priority", int'(tmr_value_o), 64);
    ev(); chk("R8 after write", int'(tmr_value_o), 65);

    // Pin rising, timer undivided; then with ratio 2
    wr_mode(6'h28); wr_tmr(8'h00);
    for (int t = 1; t <= 8; t++) begin
      pin_i = ~pin_i; cyc();
      chk("R4 rising edge", int'(tmr_value_o), (t + 1) / 2);
    end
    wr_mode(6'h38); wr_tmr(8'h00);
    for (int t = 1; t <= 8; t++) begin
      pin_i = ~pin_i; cyc();
      chk("R4 falling edge", int'(tmr_value_o), t / 2);
    end
    wr_mode(6'h20); wr_tmr(8'h00);
    for (int t = 1; t <= 8; t++) begin
      pin_i = ~pin_i; cyc();
      chk("R4 R5 pin ratio 2", int'(tmr_value_o), ((t + 1) / 2) / 2);
    end
    pin_i = 1'b0; cyc();

    // Timer write clears prescaler when it serves the timer
    wr_mode(6'h01); wr_tmr(8'h10);
    repeat (3) ev();
    wr_tmr(8'h20);
    repeat (3) ev();
    chk("R8 prescaler cleared", int'(tmr_value_o), 32);
    ev(); chk("R8 fresh ratio", int'(tmr_value_o), 33);

    // Watchdog clear leaves timer prescaler untouched
    wr_tmr(8'h00);
    repeat (2) ev();
    clr_wdt();
    repeat (2) ev();
    chk("R9 timer prescaler kept", int'(tmr_value_o), 1);

    // Watchdog ratio sweep
    for (int s = 0; s < 8; s++) begin
      wr_mode(6'h08 | 6'(s));
      clr_wdt();
      run_wdt(n);
      chk($sformatf("R7 wdt ratio s=%0d", s), n, 256 << s);
    end
    chk("R6 timer idle during wdt", int'(tmr_value_o), 1);

    // Watchdog undivided when prescaler serves timer
    wr_mode(6'h07); clr_wdt();
    run_wdt(n);
    chk("R7 wdt undivided", n, 256);

    // Clear mid-count restarts watchdog and its prescaler
    wr_mode(6'h0A); clr_wdt();
    wdt_tick_i = 1'b1; repeat (601) cyc(); wdt_tick_i = 1'b0;
    clr_wdt();
    run_wdt(n);
    chk("R9 clear restarts", n, 1024);

    // Timer write does not clear watchdog-owned prescaler
    wr_mode(6'h09); clr_wdt();
    wdt_tick_i = 1'b1; cyc(); wdt_tick_i = 1'b0;
    wr_tmr(8'h55);
    chk("R8 timer load", int'(tmr_value_o), 85);
    run_wdt(n);
    chk("R8 wdt prescaler kept", n, 511);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule